// File: doc/BRIEF.md
# Rotating-Parity Five-Disk Array Controller

The block sits between a single request port and five independent disk ports and serves one logical block at a time. It turns a logical block number into a stripe number and a member disk. The parity member moves down by one disk on each successive stripe. Data blocks take the remaining disks in ascending order. Every disk port is word addressed, and the stripe number serves directly as the word address on every disk.

A logical read becomes one physical read of the data disk. When that disk is marked failed, the read goes instead to the four surviving members of the stripe, and the controller returns the XOR of the four words. A logical write is a read-modify-write:

- The old data and the old parity are read at the same time.
- Once both words have returned, the new data and the new parity are written together.
- The new parity is the old parity XOR the old data XOR the new data.

A write whose data disk or parity disk is marked failed is refused with an error flag, and no disk is touched.

Top module: `raid5_ctrl`

## Requirements
- R1: The stripe of logical block L is L/4. The parity disk of stripe S is 4 - (S mod 5), so stripes 0..4 keep parity on disks 4, 3, 2, 1, 0 and the pattern then repeats.
- R2: Data slot k = L mod 4 goes to the k-th non-parity disk of the stripe, counting disks in ascending order. Every physical access uses the stripe number as the word address.
- R3: A read of a block on a healthy disk issues exactly one physical read, to the data disk. It completes with that disk's word on done_rdata.
- R4: A write issues one pulse that reads the data disk and the parity disk together. After both responses have arrived, it issues one pulse that writes both disks. The parity disk receives old parity ^ old data ^ new data, and the data disk receives the new data.
- R5: A write touches only its data disk and its parity disk. Block 0 touches disks {0,4} and block 5 touches disks {1,3}.
- R6: When fail_valid is high and fail_disk equals the data disk of a read, the controller reads the four other disks of the stripe. It returns their XOR, which equals the lost block.
- R7: A write whose data disk or parity disk equals a valid fail_disk completes with done_err high. It issues no disk request and leaves the array unchanged.
- R8: req_ready is high only while the controller is idle, so at most one request is in flight. done is a single-cycle pulse that ends every request.
- R9: Each disk request (dk_req, dk_we) is a one-cycle pulse. No dependent step is issued before every response it waits for has arrived on dk_ack.
- R10: After reset, req_ready is 1, done is 0 and no disk request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | SW+2 | Logical block number |
| req_wdata | input | DW | Write data |
| fail_valid | input | 1 | fail_disk is meaningful |
| fail_disk | input | 3 | Index of the failed disk |
| done | output | 1 | Request complete (one cycle) |
| done_err | output | 1 | Write refused because a disk it needs has failed |
| done_rdata | output | DW | Read result, valid with done |
| dk_req | output | 5 | Per-disk request pulse |
| dk_we | output | 5 | Per-disk write enable, qualified by dk_req |
| dk_addr | output | 5*SW | Per-disk word address |
| dk_wdata | output | 5*DW | Per-disk write word |
| dk_ack | input | 5 | Per-disk response pulse |
| dk_rdata | input | 5*DW | Per-disk read word, valid with dk_ack |

## Verification
Directed reads of blocks 7, 12, 13, 19 and 20 land on different parity rotations and on both sides of the parity disk, which separates a correct slot-skip rule from an off-by-one or a reversed rotation. Writes to blocks 0 and 5 pin down the touched disk pairs. After every write the XOR of all five disks in the stripe must be zero, so a parity update that drops the old data or the old parity shows up at once. Random mixes of reads and writes run with a failed disk that is absent, equal to the data disk or equal to the parity disk, and the disks answer with random latency. These runs separate degraded reconstruction and write rejection from the normal paths and expose any step issued before its responses have arrived.

// File: rtl/raid5_pkg.sv
package raid5_pkg;
    localparam int NDISK = 5;
    localparam int SLOTS = NDISK - 1;

    typedef logic [2:0] disk_t;
    typedef logic [NDISK-1:0] dmask_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    typedef struct packed {
        disk_t data_disk;
        disk_t par_disk;
    } place_t;

    function automatic disk_t parity_for(input int unsigned stripe_mod);
        return disk_t'(NDISK - 1 - stripe_mod);
    endfunction

    function automatic disk_t slot_to_disk(input logic [1:0] slot, input disk_t pd);
        disk_t s;
        s = disk_t'(slot);
        return (s < pd) ? s : disk_t'(s + 3'd1);
    endfunction

    function automatic dmask_t onehot(input disk_t d);
        return dmask_t'(1) << d;
    endfunction
endpackage

// File: rtl/raid5_map.sv
module raid5_map
    import raid5_pkg::*;
#(
    parameter int SW = 4,
    localparam int LW = SW + 2
) (
    input  logic [LW-1:0] lba,
    output logic [SW-1:0] stripe,
    output place_t        place
);
    int unsigned rot;

    always_comb begin
        stripe          = lba[LW-1:2];
        rot             = int'(stripe) % NDISK;
        place.par_disk  = parity_for(rot);
        place.data_disk = slot_to_disk(lba[1:0], place.par_disk);
    end
endmodule

// File: rtl/raid5_seq.sv
module raid5_seq
    import raid5_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [DW-1:0]       req_wdata,
    input  logic [SW-1:0]       map_stripe,
    input  place_t              map_place,
    input  logic                fail_valid,
    input  disk_t               fail_disk,
    output logic                done,
    output logic                done_err,
    output logic [DW-1:0]       done_rdata,
    output dmask_t              dk_req,
    output dmask_t              dk_we,
    output logic [SW-1:0]       dk_addr,
    output logic [NDISK*DW-1:0] dk_wdata,
    input  dmask_t              dk_ack,
    input  logic [NDISK*DW-1:0] dk_rdata
);
    state_e        st_q;
    logic          wr_q;
    place_t        pl_q;
    logic [DW-1:0] new_q;
    logic [DW-1:0] acc_q;
    dmask_t        pend_q;
    logic          err_q;

    dmask_t        hit;
    dmask_t        left;
    logic [DW-1:0] acc_nx;
    logic          bad_wr;
    logic          degraded;
    dmask_t        pair;

    always_comb begin
        hit    = dk_ack & pend_q;
        left   = pend_q & ~dk_ack;
        acc_nx = acc_q;
        for (int i = 0; i < NDISK; i++) begin
            if (hit[i]) acc_nx = acc_nx ^ dk_rdata[i*DW +: DW];
        end
        bad_wr   = fail_valid && (fail_disk == map_place.data_disk ||
                                  fail_disk == map_place.par_disk);
        degraded = fail_valid && (fail_disk == map_place.data_disk);
        pair     = onehot(pl_q.data_disk) | onehot(pl_q.par_disk);
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign done       = (st_q == ST_DONE);
    assign done_err   = err_q;
    assign done_rdata = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            wr_q     <= 1'b0;
            pl_q     <= '0;
            new_q    <= '0;
            acc_q    <= '0;
            pend_q   <= '0;
            err_q    <= 1'b0;
            dk_req   <= '0;
            dk_we    <= '0;
            dk_addr  <= '0;
            dk_wdata <= '0;
        end else begin
            dk_req <= '0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        pl_q    <= map_place;
                        new_q   <= req_wdata;
                        dk_addr <= map_stripe;
                        dk_we   <= '0;
                        if (req_write && bad_wr) begin
                            err_q <= 1'b1;
                            acc_q <= '0;
                            st_q  <= ST_DONE;
                        end else if (req_write) begin
                            dk_req <= onehot(map_place.data_disk) | onehot(map_place.par_disk);
                            pend_q <= onehot(map_place.data_disk) | onehot(map_place.par_disk);
                            acc_q  <= req_wdata;
                            st_q   <= ST_READ;
                        end else if (degraded) begin
                            dk_req <= ~onehot(map_place.data_disk);
                            pend_q <= ~onehot(map_place.data_disk);
                            acc_q  <= '0;
                            st_q   <= ST_READ;
                        end else begin
                            dk_req <= onehot(map_place.data_disk);
                            pend_q <= onehot(map_place.data_disk);
                            acc_q  <= '0;
                            st_q   <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    acc_q  <= acc_nx;
                    pend_q <= left;
                    if (left == '0) begin
                        if (wr_q) begin
                            dk_req <= pair;
                            dk_we  <= pair;
                            pend_q <= pair;
                            for (int i = 0; i < NDISK; i++) begin
                                dk_wdata[i*DW +: DW] <= (disk_t'(i) == pl_q.par_disk) ? acc_nx : new_q;
                            end
                            st_q <= ST_WRITE;
                        end else begin
                            st_q <= ST_DONE;
                        end
                    end
                end
                ST_WRITE: begin
                    pend_q <= left;
                    if (left == '0) st_q <= ST_DONE;
                end
                default: begin
                    err_q <= 1'b0;
                    st_q  <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/raid5_ctrl.sv
module raid5_ctrl
    import raid5_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4,
    localparam int LW = SW + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LW-1:0]       req_lba,
    input  logic [DW-1:0]       req_wdata,
    input  logic                fail_valid,
    input  logic [2:0]          fail_disk,
    output logic                done,
    output logic                done_err,
    output logic [DW-1:0]       done_rdata,
    output logic [NDISK-1:0]    dk_req,
    output logic [NDISK-1:0]    dk_we,
    output logic [NDISK*SW-1:0] dk_addr,
    output logic [NDISK*DW-1:0] dk_wdata,
    input  logic [NDISK-1:0]    dk_ack,
    input  logic [NDISK*DW-1:0] dk_rdata
);
    logic [SW-1:0] stripe;
    place_t        place;
    logic [SW-1:0] addr_one;

    raid5_map #(.SW(SW)) u_map (
        .lba    (req_lba),
        .stripe (stripe),
        .place  (place)
    );

    raid5_seq #(.DW(DW), .SW(SW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .map_stripe (stripe),
        .map_place  (place),
        .fail_valid (fail_valid),
        .fail_disk  (fail_disk),
        .done       (done),
        .done_err   (done_err),
        .done_rdata (done_rdata),
        .dk_req     (dk_req),
        .dk_we      (dk_we),
        .dk_addr    (addr_one),
        .dk_wdata   (dk_wdata),
        .dk_ack     (dk_ack),
        .dk_rdata   (dk_rdata)
    );

    for (genvar g = 0; g < NDISK; g++) begin : g_addr
        assign dk_addr[g*SW +: SW] = addr_one;
    end
endmodule

// File: rtl/raid5_chk.sv
module raid5_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       done_err,
    input logic [4:0] dk_req,
    input logic [4:0] dk_we
);
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
        (dk_req != 5'd0) |=> (dk_req == 5'd0));

    a_r4_no_mixed_access: assert property (@(posedge clk) disable iff (rst)
        ((dk_req & dk_we) != 5'd0) |-> ((dk_req & ~dk_we) == 5'd0));

    a_r5_write_pair: assert property (@(posedge clk) disable iff (rst)
        ((dk_req & dk_we) != 5'd0) |-> ($countones(dk_req) == 2));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        done_err |-> done);

    a_r9_no_req_when_idle: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !$past(req_ready)) |-> (dk_req == 5'd0));
endmodule

bind raid5_ctrl raid5_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .done_err  (done_err),
    .dk_req    (dk_req),
    .dk_we     (dk_we)
);

// File: tb/sim_raid5_ctrl.sv
module sim_raid5_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int SW = 4;
    localparam int LW = SW + 2;
    localparam int NS = 1 << SW;
    localparam int NB = NS * 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [LW-1:0]   req_lba = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            fail_valid = 1'b0;
    logic [2:0]      fail_disk = 3'd0;
    logic            done;
    logic            done_err;
    logic [DW-1:0]   done_rdata;
    logic [4:0]      dk_req;
    logic [4:0]      dk_we;
    logic [5*SW-1:0] dk_addr;
    logic [5*DW-1:0] dk_wdata;
    logic [4:0]      dk_ack = '0;
    logic [5*DW-1:0] dk_rdata = '0;

    raid5_ctrl #(.DW(DW), .SW(SW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] mem  [5][NS];
    logic [DW-1:0] gold [NB];
    int   nchk = 0;
    int   nfail = 0;
    bit   finished = 0;
    int   npulse;
    logic [4:0] p0mask, p1mask;
    logic p0we, p1we;
    int   last_addr [5];

    function automatic int par_of(int s);
        return 4 - (s % 5);
    endfunction

    function automatic int disk_of(int lba);
        int pd, slot, cnt;
        pd = par_of(lba / 4);
        slot = lba % 4;
        cnt = 0;
        for (int d = 0; d < 5; d++) begin
            if (d != pd) begin
                if (cnt == slot) return d;
                cnt++;
            end
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // disk models: random latency, write applied at request time
    initial begin
        int  lat [5];
        bit  busy [5];
        int  adr [5];
        forever begin
            @(posedge clk);
            for (int d = 0; d < 5; d++) begin
                dk_ack[d] <= 1'b0;
                if (busy[d]) begin
                    if (lat[d] <= 1) begin
                        dk_ack[d] <= 1'b1;
                        dk_rdata[d*DW +: DW] <= mem[d][adr[d]];
                        busy[d] = 0;
                    end else lat[d]--;
                end
                if (!rst && dk_req[d]) begin
                    busy[d] = 1;
                    lat[d] = 1 + int'($urandom % 3);
                    adr[d] = int'(dk_addr[d*SW +: SW]);
                    last_addr[d] = adr[d];
                    if (dk_we[d]) mem[d][adr[d]] = dk_wdata[d*DW +: DW];
                end
            end
            if (!rst && dk_req != 5'd0) begin
                if (npulse == 0) begin p0mask = dk_req; p0we = |(dk_req & dk_we); end
                else if (npulse == 1) begin p1mask = dk_req; p1we = |(dk_req & dk_we); end
                npulse++;
            end
        end
    end

    task automatic run_op(input bit wr, input int lba, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output bit err);
        int n;
        npulse = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lba = LW'(lba); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        chk(n < 200, "R8 completion", n, 0);
        rd = done_rdata;
        err = done_err;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] stripe_xor(int s);
        logic [DW-1:0] x = '0;
        for (int d = 0; d < 5; d++) x ^= mem[d][s];
        return x;
    endfunction

    // full checked operation against the bench model
    task automatic do_read(input int lba);
        logic [DW-1:0] rd; bit err; int d, s; logic [4:0] em;
        d = disk_of(lba); s = lba / 4;
        run_op(0, lba, '0, rd, err);
        chk(rd == gold[lba], "R3/R6 read data", rd, gold[lba]);
        em = (fail_valid && fail_disk == 3'(d)) ? (5'h1f & ~(5'd1 << d)) : (5'd1 << d);
        chk(npulse == 1 && p0mask == em && !p0we, "R2/R6 read disks", p0mask, em);
        chk(last_addr[d == 0 ? 1 : 0] == s || em == (5'd1 << d) ? last_addr[em == (5'd1 << d) ? d : (d == 0 ? 1 : 0)] == s : 1'b0,
            "R2 address", last_addr[d], s);
    endtask

    task automatic do_write(input int lba, input logic [DW-1:0] wd);
        logic [DW-1:0] rd; bit err; int d, p, s; logic [4:0] em;
        d = disk_of(lba); s = lba / 4; p = par_of(s);
        em = (5'd1 << d) | (5'd1 << p);
        run_op(1, lba, wd, rd, err);
        if (fail_valid && (fail_disk == 3'(d) || fail_disk == 3'(p))) begin
            chk(err == 1'b1, "R7 error flag", err, 1);
            chk(npulse == 0, "R7 no disk access", npulse, 0);
            chk(mem[d][s] == gold[lba], "R7 data unchanged", mem[d][s], gold[lba]);
        end else begin
            gold[lba] = wd;
            chk(err == 1'b0, "R4 no error", err, 0);
            chk(npulse == 2 && p0mask == em && !p0we && p1mask == em && p1we,
                "R4/R5 read pair then write pair", {p0mask, p1mask}, {em, em});
            chk(mem[d][s] == wd, "R4 new data", mem[d][s], wd);
            chk(stripe_xor(s) == '0, "R4 parity consistent", stripe_xor(s), 0);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000 && !finished) begin @(posedge clk); cyc++; end
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) begin
            mem[par_of(s)][s] = '0;
            for (int k = 0; k < 4; k++) begin
                gold[s*4+k] = DW'($urandom);
                mem[disk_of(s*4+k)][s] = gold[s*4+k];
                mem[par_of(s)][s] ^= gold[s*4+k];
            end
        end
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
        chk(dk_req == 5'd0, "R10 no request", dk_req, 0);
        chk(done == 1'b0, "R10 done low", done, 0);

        // R1/R2 placement via single-disk reads
        do_read(7);  chk(p0mask == 5'b10000, "R1 block 7 on disk 4", p0mask, 5'b10000);
        do_read(12); chk(p0mask == 5'b00001, "R1 block 12 on disk 0", p0mask, 5'b00001);
        do_read(13); chk(p0mask == 5'b00100, "R2 block 13 on disk 2", p0mask, 5'b00100);
        do_read(19); chk(p0mask == 5'b10000, "R1 block 19 on disk 4", p0mask, 5'b10000);
        do_read(20); chk(p0mask == 5'b00001, "R1 block 20 on disk 0", p0mask, 5'b00001);

        // R5 touched disks of blocks 0 and 5
        do_write(0, 16'hA5A5); chk(p0mask == 5'b10001, "R5 block 0 disks", p0mask, 5'b10001);
        do_write(5, 16'h3C3C); chk(p0mask == 5'b01010, "R5 block 5 disks", p0mask, 5'b01010);

        // R6 degraded read, R7 rejections
        fail_valid = 1'b1; fail_disk = 3'd1;
        do_read(5);
        do_write(5, 16'h1111);
        do_write(4 * 3, 16'h2222);   // parity of stripe 3 on disk 1
        do_write(0, 16'h5A5A);       // disks 0 and 4: allowed
        fail_valid = 1'b0;
        do_read(5);

        // random mix
        for (int i = 0; i < 120; i++) begin
            int lba, mode;
            lba = int'($urandom % NB);
            mode = int'($urandom % 3);
            fail_valid = (mode != 0);
            fail_disk = 3'($urandom % 5);
            if ($urandom % 2) do_write(lba, DW'($urandom));
            else do_read(lba);
        end
        fail_valid = 1'b0;
        for (int lba = 0; lba < NB; lba += 5) do_read(lba);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule